// File: doc/BRIEF.md
# Widescreen Line Compressor Timing Controller

This block sequences one video line for a 3/4 horizontal compressor. The analog part of the compressor has line memories, a side-panel source and a direct path. The block counts system clocks from the rising edge of the horizontal reference pulse. From that count it drives:

- the input clamp window;
- the write strobes and clock enables for the line memories;
- the read strobes and clock enables for the line memories;
- two output multiplexer selects.

A 3-bit mode code picks one of five behaviours:

- a pass through the memories;
- compression with the picture placed left;
- compression with the picture placed centre;
- compression with the picture placed right;
- a direct path that skips the memories.

The mode code is taken only at a reference edge, so a line is never split between two modes. Every path through the memories shows its output one line late. For that reason the block lowers an output-valid flag for the first line after a change of mode. A test input forces the direct-path state.

If the reference pulse stops arriving, the line counter keeps running at the nominal line length and a lock-lost flag is raised. The next reference edge restarts normal timing.

Top module: `ar_comp_ctrl`

## Requirements

Position p is the clock cycle that begins p clock edges after the first edge at which `href_i` is sampled high.

- R1: The mode code decodes as follows: 000 is the pass through the memories, 011 is left compression, 010 is centre compression, 100 is right compression, and 001 and every other code is the direct path. `c1_o` is 1 in every mode that uses the memories and 0 in the direct path.
- R2: `mode_i` is taken only at a reference edge. A change of `mode_i` during a line has no effect at the outputs before the next reference edge.
- R3: `clamp_o` is high exactly for positions CLAMP_ON to CLAMP_OFF-1, in every mode.
- R4: In modes that use the memories, `wr_en_o` is high at every active position ACT_START to ACT_START+ACT_LEN-1, except those whose distance from ACT_START is 3 modulo 4. `wr_start_o` pulses at position ACT_START. In the direct path both stay low.
- R5: In compression modes, the read window lasts ACT_LEN*3/4 positions, with `rd_en_o` high on every clock. It starts at ACT_START plus the left, centre or right offset, and `rd_start_o` pulses on its first position.
- R6: In the pass through the memories, `rd_en_o` and `rd_start_o` follow exactly the pattern of `wr_en_o` and `wr_start_o`.
- R7: In compression modes, `c2_o` (side-panel select) is high at every position outside the read window and low inside it. In the other modes it is low.
- R8: `valid_o` is always high in the direct path. In the other modes it is low during the first line after a reference edge that changed the mode, and high from the following line on.
- R9: While `test_i` is high, the outputs take the direct-path values at once: `c1_o`, `c2_o` and all strobes and enables low, and `valid_o` high.
- R10: If there is no reference edge for LINE_CLKS*5/4 clocks, a new line starts and `lock_lost_o` rises. The counter then wraps every LINE_CLKS clocks. The next reference edge clears `lock_lost_o` and restarts the line.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href_i | input | 1 | Horizontal reference pulse; its rising edge starts a line |
| mode_i | input | 3 | Mode code, taken at the reference edge |
| test_i | input | 1 | Forces the direct-path state when high |
| clamp_o | output | 1 | Input clamp window |
| wr_start_o | output | 1 | Line memory write start strobe |
| wr_en_o | output | 1 | Line memory write clock enable |
| rd_start_o | output | 1 | Line memory read start strobe |
| rd_en_o | output | 1 | Line memory read clock enable |
| c1_o | output | 1 | First multiplexer select: 1 = memory output, 0 = direct path |
| c2_o | output | 1 | Second multiplexer select: 1 = side panel, 0 = first multiplexer result |
| valid_o | output | 1 | Output path carries valid picture |
| lock_lost_o | output | 1 | Reference pulse missing; line timing is free-running |

## Verification

A wrong line position shifts every window. The clamp, write and read edges then move away from their expected positions within the first line after a reference edge. A wrongly latched mode shows in `c1_o`, `c2_o` and the read offset from the cycle after the edge. A wrong settle flag shows as `valid_o` being wrong for one whole line. A faulty timeout only appears once a full 1.25-line gap has passed without an edge, so the bench leaves the reference out for that long and then checks the free-running lines one by one.

// File: rtl/ar_pkg.sv
package ar_pkg;

    typedef enum logic [2:0] {
        MODE_BYP_MEM = 3'b000,
        MODE_BYP_DIR = 3'b001,
        MODE_CMP_C   = 3'b010,
        MODE_CMP_L   = 3'b011,
        MODE_CMP_R   = 3'b100
    } ar_mode_e;

    typedef struct packed {
        logic clamp;
        logic wr_start;
        logic wr_en;
        logic rd_start;
        logic rd_en;
        logic c1;
        logic c2;
        logic valid;
    } ar_strobe_t;

    // R1: code decode; unlisted codes fall back to the direct path
    function automatic ar_mode_e ar_decode(input logic [2:0] code);
        ar_mode_e m;
        case (code)
            3'b000:  m = MODE_BYP_MEM;
            3'b011:  m = MODE_CMP_L;
            3'b010:  m = MODE_CMP_C;
            3'b100:  m = MODE_CMP_R;
            default: m = MODE_BYP_DIR;
        endcase
        return m;
    endfunction

    function automatic logic ar_is_cmp(input ar_mode_e m);
        return (m == MODE_CMP_L) || (m == MODE_CMP_C) || (m == MODE_CMP_R);
    endfunction

endpackage

// File: rtl/ar_line_timer.sv
module ar_line_timer #(
    parameter int LINE_CLKS = 1728,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          href_i,
    output logic [CW-1:0] pos_o,
    output logic          edge_o,
    output logic          line_start_o,
    output logic          lost_o
);
    localparam int TIMEOUT = LINE_CLKS + LINE_CLKS / 4;

    typedef struct packed {
        logic          href;
        logic [CW-1:0] pos;
        logic          lost;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic edge_s, timeout_s, wrap_s;

    always_comb begin
        tmr_d      = tmr_q;
        edge_s     = href_i & ~tmr_q.href;
        timeout_s  = !tmr_q.lost && (tmr_q.pos == CW'(TIMEOUT - 1));
        wrap_s     = tmr_q.lost && (tmr_q.pos == CW'(LINE_CLKS - 1));
        tmr_d.href = href_i;
        if (edge_s || timeout_s || wrap_s) begin
            tmr_d.pos = '0;
        end else begin
            tmr_d.pos = tmr_q.pos + CW'(1);
        end
        if (edge_s) begin
            tmr_d.lost = 1'b0;
        end else if (timeout_s) begin
            tmr_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pos_o        = tmr_q.pos;
    assign edge_o       = edge_s;
    assign line_start_o = edge_s | timeout_s | wrap_s;
    assign lost_o       = tmr_q.lost;

endmodule

// File: rtl/ar_mode_track.sv
module ar_mode_track
    import ar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    input  logic       line_start_i,
    input  logic [2:0] code_i,
    output ar_mode_e   mode_o,
    output logic       settled_o
);
    typedef struct packed {
        ar_mode_e mode;
        logic     settled;
    } trk_t;

    trk_t trk_d, trk_q;
    ar_mode_e new_mode;

    always_comb begin
        trk_d    = trk_q;
        new_mode = ar_decode(code_i);
        if (edge_i) begin
            trk_d.mode    = new_mode;
            trk_d.settled = (new_mode == trk_q.mode);
        end else if (line_start_i) begin
            trk_d.settled = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.mode    <= MODE_BYP_DIR;
            trk_q.settled <= 1'b1;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign mode_o    = trk_q.mode;
    assign settled_o = trk_q.settled;

endmodule

// File: rtl/ar_strobe_gen.sv
module ar_strobe_gen
    import ar_pkg::*;
#(
    parameter int CW        = 11,
    parameter int ACT_START = 264,
    parameter int ACT_LEN   = 1440,
    parameter int CLAMP_ON  = 42,
    parameter int CLAMP_OFF = 102,
    parameter int RD_OFS_L  = 0,
    parameter int RD_OFS_C  = 180,
    parameter int RD_OFS_R  = 360
) (
    input  logic [CW-1:0] pos_i,
    input  ar_mode_e      mode_i,
    input  logic          settled_i,
    input  logic          test_i,
    output ar_strobe_t    strobe_o
);
    localparam int RD_LEN  = (ACT_LEN * 3) / 4;
    localparam int ACT_END = ACT_START + ACT_LEN;
    localparam int NPOS    = 3;
    localparam int OFS [NPOS] = '{RD_OFS_L, RD_OFS_C, RD_OFS_R};

    int p;
    logic [NPOS-1:0] win_hit, win_first;

    assign p = int'(pos_i);

    genvar g;
    generate
        for (g = 0; g < NPOS; g++) begin : g_win
            assign win_hit[g]   = (p >= ACT_START + OFS[g]) && (p < ACT_START + OFS[g] + RD_LEN);
            assign win_first[g] = (p == ACT_START + OFS[g]);
        end
    endgenerate

    ar_mode_e eff;
    logic     mem, cmp, act, skip;
    int       idx;

    always_comb begin
        strobe_o = '0;
        eff  = test_i ? MODE_BYP_DIR : mode_i;
        mem  = (eff != MODE_BYP_DIR);
        cmp  = ar_is_cmp(eff);
        act  = (p >= ACT_START) && (p < ACT_END);
        skip = (((p - ACT_START) & 3) == 3);
        case (eff)
            MODE_CMP_L: idx = 0;
            MODE_CMP_C: idx = 1;
            default:    idx = 2;
        endcase
        strobe_o.clamp    = (p >= CLAMP_ON) && (p < CLAMP_OFF);
        strobe_o.wr_en    = mem && act && !skip;
        strobe_o.wr_start = mem && (p == ACT_START);
        if (cmp) begin
            strobe_o.rd_en    = win_hit[idx];
            strobe_o.rd_start = win_first[idx];
        end else if (mem) begin
            strobe_o.rd_en    = strobe_o.wr_en;
            strobe_o.rd_start = strobe_o.wr_start;
        end
        strobe_o.c1    = mem;
        strobe_o.c2    = cmp && !strobe_o.rd_en;
        strobe_o.valid = !mem || settled_i;
    end

endmodule

// File: rtl/ar_comp_ctrl.sv
module ar_comp_ctrl
    import ar_pkg::*;
#(
    parameter int LINE_CLKS = 1728,
    parameter int ACT_START = 264,
    parameter int ACT_LEN   = 1440,
    parameter int CLAMP_ON  = 42,
    parameter int CLAMP_OFF = 102,
    parameter int RD_OFS_L  = 0,
    parameter int RD_OFS_C  = ACT_LEN / 8,
    parameter int RD_OFS_R  = ACT_LEN / 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       href_i,
    input  logic [2:0] mode_i,
    input  logic       test_i,
    output logic       clamp_o,
    output logic       wr_start_o,
    output logic       wr_en_o,
    output logic       rd_start_o,
    output logic       rd_en_o,
    output logic       c1_o,
    output logic       c2_o,
    output logic       valid_o,
    output logic       lock_lost_o
);
    localparam int TIMEOUT = LINE_CLKS + LINE_CLKS / 4;
    localparam int CW      = $clog2(TIMEOUT + 1);

    logic [CW-1:0] pos;
    logic          edge_s, line_start, lost;
    ar_mode_e      mode;
    logic          settled;
    ar_strobe_t    strb;

    ar_line_timer #(.LINE_CLKS(LINE_CLKS), .CW(CW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .href_i       (href_i),
        .pos_o        (pos),
        .edge_o       (edge_s),
        .line_start_o (line_start),
        .lost_o       (lost)
    );

    ar_mode_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_i       (edge_s),
        .line_start_i (line_start),
        .code_i       (mode_i),
        .mode_o       (mode),
        .settled_o    (settled)
    );

    ar_strobe_gen #(
        .CW(CW), .ACT_START(ACT_START), .ACT_LEN(ACT_LEN),
        .CLAMP_ON(CLAMP_ON), .CLAMP_OFF(CLAMP_OFF),
        .RD_OFS_L(RD_OFS_L), .RD_OFS_C(RD_OFS_C), .RD_OFS_R(RD_OFS_R)
    ) u_strobe (
        .pos_i     (pos),
        .mode_i    (mode),
        .settled_i (settled),
        .test_i    (test_i),
        .strobe_o  (strb)
    );

    assign clamp_o     = strb.clamp;
    assign wr_start_o  = strb.wr_start;
    assign wr_en_o     = strb.wr_en;
    assign rd_start_o  = strb.rd_start;
    assign rd_en_o     = strb.rd_en;
    assign c1_o        = strb.c1;
    assign c2_o        = strb.c2;
    assign valid_o     = strb.valid;
    assign lock_lost_o = lost;

endmodule

// File: rtl/ar_comp_ctrl_chk.sv
module ar_comp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic test_i,
    input logic wr_start_o,
    input logic wr_en_o,
    input logic rd_start_o,
    input logic rd_en_o,
    input logic c1_o,
    input logic c2_o,
    input logic valid_o,
    input logic line_start
);
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c1_o) |-> (!$stable(test_i) || $past(line_start)));

    p_wr_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> (wr_en_o && c1_o));

    p_rd_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_o |-> rd_en_o);

    p_side_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c2_o |-> (!rd_en_o && c1_o));

    p_test_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        test_i |-> (!c1_o && !c2_o && !wr_en_o && !rd_en_o && valid_o));

endmodule

bind ar_comp_ctrl ar_comp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_i     (test_i),
    .wr_start_o (wr_start_o),
    .wr_en_o    (wr_en_o),
    .rd_start_o (rd_start_o),
    .rd_en_o    (rd_en_o),
    .c1_o       (c1_o),
    .c2_o       (c2_o),
    .valid_o    (valid_o),
    .line_start (line_start)
);

// File: tb/test_ar_comp_ctrl.sv
module test_ar_comp_ctrl;
    localparam int LC  = 200;
    localparam int AS  = 108;
    localparam int AL  = 80;
    localparam int CON = 42;
    localparam int COF = 102;
    localparam int TO  = LC + LC / 4;
    localparam int RL  = (AL * 3) / 4;

    logic clk = 1'b0, rst_n = 1'b0, href = 1'b0, test = 1'b0;
    logic [2:0] code = 3'b001;
    logic clamp_o, wr_start_o, wr_en_o, rd_start_o, rd_en_o, c1_o, c2_o, valid_o, lock_lost_o;

    ar_comp_ctrl #(.LINE_CLKS(LC), .ACT_START(AS), .ACT_LEN(AL)) i_ar_comp_ctrl (
        .clk(clk), .rst_n(rst_n), .href_i(href), .mode_i(code), .test_i(test),
        .clamp_o(clamp_o), .wr_start_o(wr_start_o), .wr_en_o(wr_en_o),
        .rd_start_o(rd_start_o), .rd_en_o(rd_en_o), .c1_o(c1_o), .c2_o(c2_o),
        .valid_o(valid_o), .lock_lost_o(lock_lost_o)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [2:0] e_mode = 3'b001;
    bit e_set = 1'b1, e_lost = 1'b0;

    // R1 decode model
    function automatic logic [2:0] dec(input logic [2:0] c);
        case (c)
            3'b000, 3'b011, 3'b010, 3'b100: return c;
            default: return 3'b001;
        endcase
    endfunction

    // bits: clamp wr_start wr_en rd_start rd_en c1 c2 valid lost
    function automatic logic [8:0] expv(input int p, input logic [2:0] m, input bit s,
                                        input bit t, input bit l);
        logic [2:0] e;
        bit mem, cmp, act, ws, we, rs, re, win;
        int off;
        e   = t ? 3'b001 : m;                       // R9
        mem = (e != 3'b001);
        cmp = (e == 3'b011) || (e == 3'b010) || (e == 3'b100);
        act = (p >= AS) && (p < AS + AL);
        we  = mem && act && (((p - AS) % 4) != 3);  // R4
        ws  = mem && (p == AS);
        off = (e == 3'b011) ? 0 : (e == 3'b010) ? AL / 8 : AL / 4;
        win = (p >= AS + off) && (p < AS + off + RL);
        if (cmp) begin re = win; rs = (p == AS + off); end        // R5
        else if (mem) begin re = we; rs = ws; end                 // R6
        else begin re = 1'b0; rs = 1'b0; end
        return {(p >= CON) && (p < COF), ws, we, rs, re, mem, cmp && !win,
                !mem || s, l};
    endfunction

    task automatic chk(input int p);
        logic [8:0] got, exp;
        string tg;
        got = {clamp_o, wr_start_o, wr_en_o, rd_start_o, rd_en_o, c1_o, c2_o, valid_o, lock_lost_o};
        exp = expv(p, e_mode, e_set, test, e_lost);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            for (int b = 8; b >= 0; b--) begin
                if (got[b] !== exp[b]) begin
                    case (b)
                        8: tg = "R3";
                        7, 6: tg = "R4";
                        5, 4: tg = (e_mode == 3'b000) ? "R6" : "R5";
                        3: tg = "R1";
                        2: tg = "R7";
                        1: tg = "R8";
                        default: tg = "R10";
                    endcase
                    if (test) tg = {tg, "/R9"};
                    $display("FAIL %s pos %0d mode %b bit %0d got %b exp %b",
                             tg, p, e_mode, b, got, exp);
                end
            end
        end
    endtask

    // one line of len positions; mode_i changes mid-line (R2)
    task automatic run_line(input int len, input bit edge_next, input logic [2:0] nxt,
                            input bit pulse_test);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            chk(p);
            if (p == 3) href = 1'b0;
            if (p == len / 2) code = nxt;
            if (pulse_test && p == len / 3) test = 1'b1;
            if (pulse_test && p == (2 * len) / 3) test = 1'b0;
            if (edge_next && p == len - 1) href = 1'b1;
        end
        if (edge_next) begin
            e_set  = (dec(code) == e_mode);   // R8
            e_mode = dec(code);
            e_lost = 1'b0;
        end
    endtask

    initial begin
        logic [2:0] dir [8];
        void'($urandom(32'd4242));
        dir = '{3'b000, 3'b011, 3'b010, 3'b100, 3'b001, 3'b101, 3'b110, 3'b111};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(0);                      // reset state
        rst_n = 1'b1;
        href  = 1'b1;
        e_set = 1'b1;
        // directed: every code, change line then settled line (R1 R8)
        foreach (dir[i]) begin
            run_line(LC, 1'b1, dir[i], 1'b0);
            run_line(LC, 1'b1, dir[i], 1'b0);
        end
        // test input during compression (R9)
        run_line(LC, 1'b1, 3'b010, 1'b0);
        run_line(LC, 1'b1, 3'b010, 1'b1);
        // missing reference: timeout then free-run lines (R10)
        run_line(TO, 1'b0, 3'b000, 1'b0);
        e_lost = 1'b1;
        e_set  = 1'b1;
        run_line(LC, 1'b0, 3'b100, 1'b0);
        e_set  = 1'b1;
        run_line(LC, 1'b1, 3'b011, 1'b0);
        run_line(LC, 1'b1, 3'b011, 1'b0);
        // constrained random lines
        for (int k = 0; k < 36; k++) begin
            run_line(LC - 5 + int'($urandom % 11), 1'b1, 3'($urandom % 8),
                     ($urandom % 6) == 0);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule